// File: doc/BRIEF.md
# Dual-Channel DAC Update Sequencer

This block is the host-side driver for a three-wire serial link to a dual 12-bit voltage-output converter. A client hands it one request: which channel to change (A, B, or both at once), the new codes, a speed-mode setting and a power-down flag. The block builds the 16-bit command words and shifts them out on chip select, serial clock and data. Every link timing is a whole number of system clock cycles, set by a divider parameter.

A request to change both channels goes out as two frames. The first frame stages the channel B code in the converter's holding buffer and leaves both outputs alone. The second frame loads channel A and moves the staged code into channel B, so both outputs start to move together. The speed bit is latched once per request and is the same in both frames. It changes only when the request asks for a new speed, so the converter never sees a supply-current step that could glitch its outputs.

The request side is a valid/ready port. `req_ready` is the inverse of `busy`. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. While the block is busy, `req_ready` stays low and the request fields are not sampled. A client may keep `req_valid` high to wait, and nothing is lost. A pulse on `req_valid` that ends while the block is busy has no effect. `done` pulses once when the whole sequence has finished.

Top module: `dac_update_seq`

## Requirements
- R1: After reset, `dac_cs_n` and `dac_sclk` are 1, `req_ready` is 1, and `busy` and `done` are 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `busy` is high from the next cycle until completion. Fields offered while `req_ready` is low are ignored.
- R3: `dac_sclk` is high whenever `dac_cs_n` is high. `dac_sdo` changes only while `dac_sclk` is high. Each frame has exactly 16 falling edges of `dac_sclk`, and the word is sent most significant bit first.
- R4: Every low phase of `dac_sclk` lasts HALF_CYC system cycles. `dac_cs_n` is low for HALF_CYC cycles with `dac_sclk` high before the first fall. `dac_cs_n` rises HALF_CYC cycles after the last rise of `dac_sclk`.
- R5: `req_op` = 0 (channel A only) sends one word: bit 15 = 1, bit 14 = speed, bit 13 = `req_pdown`, bit 12 = 0, bits 11:0 = `req_data_a`.
- R6: `req_op` = 1 (channel B only) sends one word: bits 15..12 = 0, speed, 0, 0, and bits 11:0 = `req_data_b`.
- R7: `req_op` = 2 or 3 (both channels) sends two frames. The first has bits 15..12 = 0, speed, 0, 1 with `req_data_b`. The second has bits 15..12 = 1, speed, 0, 0 with `req_data_a`. `req_pdown` is ignored.
- R8: The speed bit is `req_speed` when `req_speed_upd` is 1. Otherwise it is the speed bit of the previous accepted request (0 after reset). Both frames of a pair carry the same value.
- R9: Between the two frames of a pair, `dac_cs_n` stays high for exactly 2*HALF_CYC+2 system cycles.
- R10: With BYTE_MODE = 1, the high phase of `dac_sclk` after the 8th bit lasts 2*HALF_CYC cycles while `dac_cs_n` stays low, so that bit period is 3*HALF_CYC. Every other bit period is 2*HALF_CYC, and with BYTE_MODE = 0 all bit periods are 2*HALF_CYC.
- R11: `done` is high for one cycle, the cycle after the final rise of `dac_cs_n` in the sequence. `busy` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 0 = A only, 1 = B only, 2 or 3 = both channels together |
| req_data_a | input | DATA_W | Code for channel A |
| req_data_b | input | DATA_W | Code for channel B |
| req_speed | input | 1 | Requested speed mode (1 = fast) |
| req_speed_upd | input | 1 | Apply `req_speed`; otherwise keep the previous speed |
| req_pdown | input | 1 | Power-down bit for a channel A only write |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sdo | output | 1 | Serial data, sampled by the converter on the falling clock edge |

## Verification
The assertions check the link-level rules on every cycle. These are the high clock level while chip select is high, data that holds still through each low clock phase, the length of each low phase, the count of 16 falling edges per frame, `busy` going high after an accept, and the single-cycle `done` placed just after chip select rises. The bench's scenarios are the only way to show the frame contents. They cover the program bits for each operation, the speed bit carried from one request to the next, and the order of staging and commit. They also cover the lead and tail times, the chip-select gap between paired frames, the longer byte-boundary period, and a pulse offered while busy being dropped.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [1:0] {
    OP_CH_A    = 2'd0,
    OP_CH_B    = 2'd1,
    OP_BOTH    = 2'd2,
    OP_BOTH_X  = 2'd3
  } dac_op_e;

  typedef enum logic [2:0] {
    F_IDLE,
    F_LEAD,
    F_LOW,
    F_HIGH,
    F_GAP,
    F_TAIL
  } frame_st_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FIRST,
    S_PAUSE,
    S_SECOND
  } seq_st_e;

endpackage

// File: rtl/dac_cmd_build.sv
module dac_cmd_build
  import dac_seq_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int WORD_W = DATA_W + 4
) (
  input  dac_op_e             op,
  input  logic                spd,
  input  logic                pd,
  input  logic [DATA_W-1:0]   code_a,
  input  logic [DATA_W-1:0]   code_b,
  output logic [WORD_W-1:0]   word_first,
  output logic [WORD_W-1:0]   word_second,
  output logic                two_frames
);

  // Program nibble order: load-A, speed, power-down, stage-only.
  always_comb begin
    two_frames  = 1'b0;
    word_second = {1'b1, spd, 1'b0, 1'b0, code_a};
    case (op)
      OP_CH_A: word_first = {1'b1, spd, pd,   1'b0, code_a};
      OP_CH_B: word_first = {1'b0, spd, 1'b0, 1'b0, code_b};
      default: begin
        word_first = {1'b0, spd, 1'b0, 1'b1, code_b};
        two_frames = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
  import dac_seq_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int HALF_CYC  = 3,
  parameter bit BYTE_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdo,
  output logic              frame_done
);

  localparam int CW = $clog2(2 * HALF_CYC + 1);
  localparam int BW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] HALF_LD  = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] WIDE_LD  = CW'(2 * HALF_CYC - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);
  localparam logic [BW-1:0] MID_BIT  = BW'(WORD_W / 2 - 1);

  frame_st_e         st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     sent;
  logic [WORD_W-1:0] sh;
  logic              stretch;

  generate
    if (BYTE_MODE) begin : g_bytes
      assign stretch = (sent == MID_BIT);
    end else begin : g_word
      assign stretch = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= F_IDLE;
      cnt        <= '0;
      sent       <= '0;
      sh         <= '0;
      cs_n       <= 1'b1;
      sclk       <= 1'b1;
      sdo        <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (st)
        F_IDLE: begin
          if (start) begin
            st   <= F_LEAD;
            cs_n <= 1'b0;
            sh   <= word;
            sdo  <= word[WORD_W-1];
            cnt  <= HALF_LD;
            sent <= '0;
          end
        end
        F_LEAD, F_HIGH, F_GAP: begin
          if (cnt == '0) begin
            st   <= F_LOW;
            sclk <= 1'b0;
            cnt  <= HALF_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        F_LOW: begin
          if (cnt == '0) begin
            sclk <= 1'b1;
            sent <= sent + 1'b1;
            if (sent == LAST_BIT) begin
              st  <= F_TAIL;
              cnt <= HALF_LD;
            end else begin
              sh  <= sh << 1;
              sdo <= sh[WORD_W-2];
              st  <= stretch ? F_GAP : F_HIGH;
              cnt <= stretch ? WIDE_LD : HALF_LD;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        F_TAIL: begin
          if (cnt == '0) begin
            cs_n       <= 1'b1;
            st         <= F_IDLE;
            frame_done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dac_update_seq.sv
module dac_update_seq
  import dac_seq_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int HALF_CYC  = 3,
  parameter bit BYTE_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [DATA_W-1:0] req_data_a,
  input  logic [DATA_W-1:0] req_data_b,
  input  logic              req_speed,
  input  logic              req_speed_upd,
  input  logic              req_pdown,
  output logic              busy,
  output logic              done,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdo
);

  localparam int WORD_W = DATA_W + 4;
  localparam int GW     = $clog2(2 * HALF_CYC + 1);
  localparam logic [GW-1:0] PAUSE_LD = GW'(2 * HALF_CYC - 1);

  seq_st_e           st;
  dac_op_e           op_q;
  logic              spd_q;
  logic              pd_q;
  logic [DATA_W-1:0] a_q;
  logic [DATA_W-1:0] b_q;
  logic [GW-1:0]     pause_cnt;
  logic              start_q;
  logic              frame_done;
  logic              pair;
  logic [WORD_W-1:0] w_first;
  logic [WORD_W-1:0] w_second;
  logic [WORD_W-1:0] tx_word;
  logic              accept;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign tx_word   = (st == S_SECOND) ? w_second : w_first;

  dac_cmd_build #(.DATA_W(DATA_W)) u_build (
    .op          (op_q),
    .spd         (spd_q),
    .pd          (pd_q),
    .code_a      (a_q),
    .code_b      (b_q),
    .word_first  (w_first),
    .word_second (w_second),
    .two_frames  (pair)
  );

  dac_frame_tx #(
    .WORD_W    (WORD_W),
    .HALF_CYC  (HALF_CYC),
    .BYTE_MODE (BYTE_MODE)
  ) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_q),
    .word       (tx_word),
    .cs_n       (dac_cs_n),
    .sclk       (dac_sclk),
    .sdo        (dac_sdo),
    .frame_done (frame_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op_q      <= OP_CH_A;
      spd_q     <= 1'b0;
      pd_q      <= 1'b0;
      a_q       <= '0;
      b_q       <= '0;
      pause_cnt <= '0;
      start_q   <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      start_q <= 1'b0;
      done    <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            op_q    <= dac_op_e'(req_op);
            spd_q   <= req_speed_upd ? req_speed : spd_q;
            pd_q    <= req_pdown;
            a_q     <= req_data_a;
            b_q     <= req_data_b;
            start_q <= 1'b1;
            busy    <= 1'b1;
            st      <= S_FIRST;
          end
        end
        S_FIRST: begin
          if (frame_done) begin
            if (pair) begin
              st        <= S_PAUSE;
              pause_cnt <= PAUSE_LD;
            end else begin
              st   <= S_IDLE;
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
        end
        S_PAUSE: begin
          if (pause_cnt == '0) begin
            start_q <= 1'b1;
            st      <= S_SECOND;
          end else begin
            pause_cnt <= pause_cnt - 1'b1;
          end
        end
        S_SECOND: begin
          if (frame_done) begin
            st   <= S_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dac_update_seq_chk.sv
module dac_update_seq_chk #(
  parameter int HALF_CYC = 3
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sclk,
  input logic sdo
);

  logic        sclk_d;
  logic [15:0] low_run;
  logic [7:0]  falls;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d  <= 1'b1;
      low_run <= '0;
      falls   <= '0;
    end else begin
      sclk_d  <= sclk;
      low_run <= sclk ? 16'd0 : low_run + 16'd1;
      if (cs_n)
        falls <= '0;
      else if (sclk_d && !sclk)
        falls <= falls + 8'd1;
    end
  end

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  p_sdo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk && $past(!sclk)) |-> $stable(sdo));

  p_sixteen_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (falls == 8'd16));

  p_low_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && !cs_n) |-> (low_run == 16'(HALF_CYC)));

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(cs_n) && !$past(cs_n, 2) && req_ready));

endmodule

bind dac_update_seq dac_update_seq_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .cs_n      (dac_cs_n),
  .sclk      (dac_sclk),
  .sdo       (dac_sdo)
);

// File: tb/dac_update_seq_bench.sv
module dac_link_probe (
  input  logic clk,
  input  logic clr,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdo,
  input  logic done
);
  int frames, falls, lead, tail, gap, min_low, max_low, min_per, max_per;
  int done_cnt, done_dist, sdo_bad, since_rise, hi_run, low_run, per_run;
  logic [15:0] word, w0, w1;
  logic cs_p, sclk_p, sdo_p, first_fall;

  initial begin
    cs_p = 1'b1; sclk_p = 1'b1; sdo_p = 1'b0; first_fall = 1'b1;
    word = '0; w0 = '0; w1 = '0; hi_run = 0; low_run = 0; per_run = 0;
  end

  always @(negedge clk) begin
    if (clr) begin
      frames = 0; falls = 0; lead = 0; tail = 0; gap = 0;
      min_low = 9999; max_low = 0; min_per = 9999; max_per = 0;
      done_cnt = 0; done_dist = 99; sdo_bad = 0; since_rise = 99;
      w0 = '0; w1 = '0;
    end else begin
      since_rise = (cs_n && !cs_p) ? 0 : since_rise + 1;
      if (!cs_n && cs_p) begin
        word = '0; lead = 0; per_run = 0; low_run = 0; first_fall = 1'b1; gap = hi_run;
      end
      if (!cs_n) begin
        if (sclk_p && !sclk) begin
          word = {word[14:0], sdo};
          falls++;
          if (!first_fall) begin
            if (per_run < min_per) min_per = per_run;
            if (per_run > max_per) max_per = per_run;
          end
          first_fall = 1'b0;
          per_run = 0;
        end
        per_run++;
        if (first_fall && sclk) lead++;
        if (!sclk) low_run++;
        if (sclk && !sclk_p) begin
          if (low_run < min_low) min_low = low_run;
          if (low_run > max_low) max_low = low_run;
          low_run = 0;
          tail = 0;
        end
        if (sclk && !first_fall) tail++;
        if (!sclk && !sclk_p && sdo != sdo_p) sdo_bad++;
      end
      if (cs_n && !cs_p) begin
        frames++;
        if (frames == 1) w0 = word; else w1 = word;
      end
      if (done) begin
        done_cnt++;
        done_dist = since_rise;
      end
    end
    hi_run = cs_n ? hi_run + 1 : 0;
    cs_p = cs_n; sclk_p = sclk; sdo_p = sdo;
  end
endmodule

module dac_update_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H0 = 1;
  localparam int H1 = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [11:0] req_data_a = '0;
  logic [11:0] req_data_b = '0;
  logic req_speed = 1'b0, req_speed_upd = 1'b0, req_pdown = 1'b0;

  logic rdy0, busy0, done0, cs0, sck0, sdo0;
  logic rdy1, busy1, done1, cs1, sck1, sdo1;

  int checks = 0;
  int errors = 0;
  logic s_exp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_update_seq #(.DATA_W(12), .HALF_CYC(H0), .BYTE_MODE(1'b0)) u_dac_update_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy0),
    .req_op(req_op), .req_data_a(req_data_a), .req_data_b(req_data_b),
    .req_speed(req_speed), .req_speed_upd(req_speed_upd), .req_pdown(req_pdown),
    .busy(busy0), .done(done0), .dac_cs_n(cs0), .dac_sclk(sck0), .dac_sdo(sdo0)
  );

  dac_update_seq #(.DATA_W(12), .HALF_CYC(H1), .BYTE_MODE(1'b1)) u_dac_update_seq_byte (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy1),
    .req_op(req_op), .req_data_a(req_data_a), .req_data_b(req_data_b),
    .req_speed(req_speed), .req_speed_upd(req_speed_upd), .req_pdown(req_pdown),
    .busy(busy1), .done(done1), .dac_cs_n(cs1), .dac_sclk(sck1), .dac_sdo(sdo1)
  );

  dac_link_probe u_probe0 (.clk(clk), .clr(clr), .cs_n(cs0), .sclk(sck0), .sdo(sdo0), .done(done0));
  dac_link_probe u_probe1 (.clk(clk), .clr(clr), .cs_n(cs1), .sclk(sck1), .sdo(sdo1), .done(done1));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic verify_link(input int inst, input int half, input bit bytes,
                             input int nfr, input int exp_w0, input int exp_w1,
                             input int fr, input int fl, input int ld, input int tl,
                             input int gp, input int mnl, input int mxl,
                             input int mnp, input int mxp, input int w0, input int w1,
                             input int dc, input int dd, input int bad);
    string p;
    p = (inst == 0) ? "i0" : "i1";
    check({"R5/R6/R7 frame count ", p}, fr, nfr);
    check({"R3 falling edges ", p}, fl, 16 * nfr);
    check({"R5/R6/R7 first word ", p}, w0, exp_w0);
    if (nfr == 2) begin
      check({"R7 second word ", p}, w1, exp_w1);
      check({"R9 cs gap ", p}, gp, 2 * half + 2);
    end
    check({"R4 lead ", p}, ld, half);
    check({"R4 tail ", p}, tl, half);
    check({"R4 min low ", p}, mnl, half);
    check({"R4 max low ", p}, mxl, half);
    check({"R10 min period ", p}, mnp, 2 * half);
    check({"R10 max period ", p}, mxp, bytes ? 3 * half : 2 * half);
    check({"R11 done pulses ", p}, dc, 1);
    check({"R11 done distance ", p}, dd, 1);
    check({"R3 sdo steady in low ", p}, bad, 0);
  endtask

  task automatic do_req(input int op, input bit upd, input bit spd, input bit pd,
                        input int da, input int db, input bit poke);
    int e0, e1, nfr, waited;
    clr = 1'b1; tick(); clr = 1'b0;
    req_valid = 1'b1; req_op = op[1:0]; req_speed_upd = upd; req_speed = spd;
    req_pdown = pd; req_data_a = da[11:0]; req_data_b = db[11:0];
    check("R2 ready before accept i0", int'(rdy0), 1);
    check("R2 ready before accept i1", int'(rdy1), 1);
    tick();
    req_valid = 1'b0;
    check("R2 busy after accept i0", int'(busy0), 1);
    check("R2 busy after accept i1", int'(busy1), 1);
    if (poke) begin
      tick(); tick();
      req_valid = 1'b1; req_op = 2'd0; req_speed_upd = 1'b1; req_speed = ~spd;
      req_pdown = 1'b1; req_data_a = 12'h5A5;
      check("R2 ready low while busy i0", int'(rdy0), 0);
      tick();
      req_valid = 1'b0;
    end
    if (upd) s_exp = spd;
    if (op == 0) begin
      e0 = (1 << 15) | (int'(s_exp) << 14) | (int'(pd) << 13) | da; e1 = 0; nfr = 1;
    end else if (op == 1) begin
      e0 = (int'(s_exp) << 14) | db; e1 = 0; nfr = 1;
    end else begin
      e0 = (int'(s_exp) << 14) | (1 << 12) | db;
      e1 = (1 << 15) | (int'(s_exp) << 14) | da; nfr = 2;
    end
    waited = 0;
    while ((u_probe0.done_cnt == 0 || u_probe1.done_cnt == 0) && waited < 2000) begin
      tick(); waited++;
    end
    tick(); tick(); tick();
    check("R11 busy cleared i0", int'(busy0), 0);
    check("R11 busy cleared i1", int'(busy1), 0);
    verify_link(0, H0, 1'b0, nfr, e0, e1, u_probe0.frames, u_probe0.falls, u_probe0.lead,
                u_probe0.tail, u_probe0.gap, u_probe0.min_low, u_probe0.max_low,
                u_probe0.min_per, u_probe0.max_per, int'(u_probe0.w0), int'(u_probe0.w1),
                u_probe0.done_cnt, u_probe0.done_dist, u_probe0.sdo_bad);
    verify_link(1, H1, 1'b1, nfr, e0, e1, u_probe1.frames, u_probe1.falls, u_probe1.lead,
                u_probe1.tail, u_probe1.gap, u_probe1.min_low, u_probe1.max_low,
                u_probe1.min_per, u_probe1.max_per, int'(u_probe1.w0), int'(u_probe1.w1),
                u_probe1.done_cnt, u_probe1.done_dist, u_probe1.sdo_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clr = 1'b1;
    repeat (3) tick();
    check("R1 cs_n in reset", int'(cs0), 1);
    rst_n = 1'b1;
    tick();
    clr = 1'b0;
    // R1: idle state after reset
    check("R1 cs_n idle i0", int'(cs0), 1);
    check("R1 sclk idle i0", int'(sck0), 1);
    check("R1 ready idle i0", int'(rdy0), 1);
    check("R1 busy idle i0", int'(busy0), 0);
    check("R1 done idle i0", int'(done0), 0);
    check("R1 cs_n idle i1", int'(cs1), 1);
    check("R1 sclk idle i1", int'(sck1), 1);
    // R8: speed starts slow; sweep ops, speed update, speed, power-down
    for (int i = 0; i < 32; i++) begin
      int da;
      if (i == 0) da = 0;
      else if (i == 31) da = 12'hFFF;
      else da = (i * 293 + 17) % 4096;
      do_req(i % 4, (i >> 2) % 2 == 1, (i >> 3) % 2 == 1, (i >> 4) % 2 == 1,
             da, 4095 - da, 1'b0);
    end
    // R2: pulse offered while busy must not change frames or the held speed
    do_req(2, 1'b1, 1'b1, 1'b0, 12'h123, 12'hABC, 1'b1);
    do_req(0, 1'b0, 1'b0, 1'b0, 12'h800, 12'h000, 1'b0);
    do_req(3, 1'b0, 1'b0, 1'b1, 12'h001, 12'hFFE, 1'b1);
    finish_run();
  end
endmodule